// File: doc/BRIEF.md
# PHY address discovery sequencer

This controller sits above a separate MDIO master and walks the 32 management addresses to find attached Ethernet transceivers. A start pulse begins a scan. The controller probes each address in turn. For every transceiver that responds as present, it reads the control and advertisement registers. It repairs the advertisement if needed and then programs the control register, either for autonegotiation or for forced media. Addresses of the PHYs it finds go into a small table, in the order they are found, and a count is reported when the scan ends.

The MDIO master is reached through a request/done handshake: one request pulse per transaction, and a single-cycle done pulse (carrying read data) when the transaction completes. Register numbers used are 0 (control), 1 (status) and 4 (advertisement). A per-slot advertisement memory survives from scan to scan and is cleared only by reset.

Top module: `phy_scan_seq`

## Requirements
- R1: A scan visits indices 1 to 32 in rising order and probes address index mod 32, so address 0 is probed last. Found addresses fill `phy_list_o` slot 0 upward in discovery order, with slot k at bits [5k+4:5k].
- R2: The scan ends as soon as MAX_PHY PHYs are found, and no further address is probed.
- R3: A PHY is present when (status & 0x8301) == 0x8001, or when status bit 15 is 0 and (status & 0x7800) != 0. Only present PHYs have register 0 or 4 read and are counted in `found_cnt_o`.
- R4: If the advertisement read has no bit of 0x01E0 set, status is read a second time, and ((status >> 6) & 0x03E0) | 1 replaces the read advertisement.
- R5: The advertisement chosen is `pref_adv_i` if it is nonzero. Otherwise it is the stored value of the current slot if that is nonzero. Otherwise it is the read (or replaced) value. The choice is stored in the slot, and it is written to register 4 only when it differs from the read value.
- R6: In autonegotiate mode, control bit 12 is set. If that changes the value, bit 9 is also set and a switch flag is raised. In forced mode, bit 12 is cleared, and the switch flag is raised if that changes the value.
- R7: Control bits 7, 8, 10, 11, 13, 14 and 15 are then cleared, and bit 8 is set from `fdx_i` and bit 13 from `spd100_i`.
- R8: Register 0 is written only if the new value differs from the read value. When the switch flag is set, it is written twice, with at least WAIT_CYC clock cycles between the two requests.
- R9: At most one MDIO transaction is outstanding at a time. A scan ends with exactly one single-cycle `scan_done_o` pulse. A start pulse during a scan is ignored.
- R10: After reset, no request, no done pulse and a zero count are shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (ignored while scanning) |
| autoneg_i | input | 1 | 1: enable autonegotiation, 0: forced media |
| fdx_i | input | 1 | Force full duplex bit in control |
| spd100_i | input | 1 | Force 100 Mb/s bit in control |
| pref_adv_i | input | 16 | Preferred advertisement, 0 means none |
| mdio_req_o | output | 1 | One-cycle transaction request |
| mdio_wr_o | output | 1 | Request is a write |
| mdio_phy_o | output | 5 | PHY address of request |
| mdio_reg_o | output | 5 | Register number of request |
| mdio_wdata_o | output | 16 | Write data |
| mdio_done_i | input | 1 | One-cycle transaction completion |
| mdio_rdata_i | input | 16 | Read data, valid with done |
| scan_done_o | output | 1 | One-cycle end-of-scan pulse |
| found_cnt_o | output | $clog2(MAX_PHY+1) | Number of PHYs found |
| phy_list_o | output | MAX_PHY*5 | Found addresses, slot 0 in low bits |

## Verification
The bench runs 256 scans. In each, one PHY's status register steps through every combination of bits 15, 14..11, 9, 8 and 0, which separates the two presence clauses from each other and from near misses. A second, always-present PHY sits at a shifted address to exercise slot ordering. Control contents, modes and the preferred advertisement vary with the pattern, so the runs cover unchanged control, single writes and double writes. Resets between blocks of runs empty the slot memory, which lets the derived-advertisement path be told apart from the stored-value path. Separate scans cover an empty bus, PHYs only at addresses 31 and 0, and a fully populated bus that fills the table early while a stray start pulse arrives.

// File: rtl/phy_scan_pkg.sv
`timescale 1ns/1ps
package phy_scan_pkg;
  localparam int AW = 5;
  localparam int DW = 16;

  localparam logic [AW-1:0] REG_CTRL = 5'd0;
  localparam logic [AW-1:0] REG_STAT = 5'd1;
  localparam logic [AW-1:0] REG_ADV  = 5'd4;

  localparam logic [DW-1:0] PRES_MASK   = 16'h8301;
  localparam logic [DW-1:0] PRES_VAL    = 16'h8001;
  localparam logic [DW-1:0] ABIL_MASK   = 16'h7800;
  localparam logic [DW-1:0] ADV_ABIL    = 16'h01E0;
  localparam logic [DW-1:0] CTL_AN_EN   = 16'h1000;
  localparam logic [DW-1:0] CTL_AN_RST  = 16'h0200;
  localparam logic [DW-1:0] CTL_FDX     = 16'h0100;
  localparam logic [DW-1:0] CTL_S100    = 16'h2000;
  localparam logic [DW-1:0] CTL_SCRUB   = 16'hED80;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_CTRL, S_ADV, S_STAT2, S_DECIDE,
    S_WADV, S_WCTL1, S_WAIT, S_WCTL2, S_NEXT, S_DONE
  } scan_state_e;

  function automatic logic phy_present(logic [DW-1:0] s);
    return ((s & PRES_MASK) == PRES_VAL) || (!s[15] && ((s & ABIL_MASK) != '0));
  endfunction

  function automatic logic [DW-1:0] adv_from_status(logic [DW-1:0] s);
    return ((s >> 6) & 16'h03E0) | 16'h0001;
  endfunction
endpackage

// File: rtl/phy_scan_eval.sv
`timescale 1ns/1ps
module phy_scan_eval
  import phy_scan_pkg::*;
(
  input  logic [DW-1:0] ctrl_i,
  input  logic [DW-1:0] adv_i,
  input  logic [DW-1:0] pref_i,
  input  logic [DW-1:0] stored_i,
  input  logic          autoneg_i,
  input  logic          fdx_i,
  input  logic          spd100_i,
  output logic [DW-1:0] to_adv_o,
  output logic [DW-1:0] new_ctrl_o,
  output logic          switch_o
);
  logic [DW-1:0] base;

  always_comb begin
    if (pref_i != '0)        to_adv_o = pref_i;
    else if (stored_i != '0) to_adv_o = stored_i;
    else                     to_adv_o = adv_i;
  end

  always_comb begin
    if (autoneg_i) begin
      base     = ctrl_i | CTL_AN_EN;
      switch_o = (base != ctrl_i);
      if (switch_o) base = base | CTL_AN_RST;
    end else begin
      base     = ctrl_i & ~CTL_AN_EN;
      switch_o = (base != ctrl_i);
    end
    new_ctrl_o = (base & ~CTL_SCRUB) | (fdx_i ? CTL_FDX : '0) | (spd100_i ? CTL_S100 : '0);
  end
endmodule

// File: rtl/phy_scan_table.sv
`timescale 1ns/1ps
module phy_scan_table
  import phy_scan_pkg::*;
#(
  parameter  int MAX_PHY = 4,
  localparam int SW = (MAX_PHY > 1) ? $clog2(MAX_PHY) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [SW-1:0]         slot_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         adv_i,
  output logic [MAX_PHY*AW-1:0] list_o,
  output logic [DW-1:0]         adv_o
);
  logic [AW-1:0] addr_q [MAX_PHY];
  logic [DW-1:0] adv_q  [MAX_PHY];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < MAX_PHY; k++) begin
        addr_q[k] <= '0;
        adv_q[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < MAX_PHY; k++) begin
        if (clr_i) addr_q[k] <= '0;
        if (we_i && (slot_i == SW'(k))) begin
          addr_q[k] <= addr_i;
          adv_q[k]  <= adv_i;
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_PHY; g++) begin : g_list
    assign list_o[g*AW +: AW] = addr_q[g];
  end

  assign adv_o = adv_q[slot_i];
endmodule

// File: rtl/phy_scan_wait.sv
`timescale 1ns/1ps
module phy_scan_wait #(
  parameter  int WAIT_CYC = 2000,
  localparam int TW = $clog2(WAIT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic [TW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= TW'(WAIT_CYC - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == '0);
endmodule

// File: rtl/phy_scan_seq.sv
`timescale 1ns/1ps
module phy_scan_seq
  import phy_scan_pkg::*;
#(
  parameter  int MAX_PHY  = 4,
  parameter  int WAIT_CYC = 2000,
  localparam int CW = $clog2(MAX_PHY + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  autoneg_i,
  input  logic                  fdx_i,
  input  logic                  spd100_i,
  input  logic [15:0]           pref_adv_i,
  output logic                  mdio_req_o,
  output logic                  mdio_wr_o,
  output logic [4:0]            mdio_phy_o,
  output logic [4:0]            mdio_reg_o,
  output logic [15:0]           mdio_wdata_o,
  input  logic                  mdio_done_i,
  input  logic [15:0]           mdio_rdata_i,
  output logic                  scan_done_o,
  output logic [CW-1:0]         found_cnt_o,
  output logic [MAX_PHY*5-1:0]  phy_list_o
);
  localparam int SW = (MAX_PHY > 1) ? $clog2(MAX_PHY) : 1;

  scan_state_e   state;
  logic [5:0]    idx;
  logic [CW-1:0] cnt;
  logic          pend;
  logic [DW-1:0] ctrl_q, adv_q, to_adv_q, new_ctrl_q;
  logic          sw_q;
  logic [DW-1:0] ev_adv, ev_ctrl, stored_adv;
  logic          ev_sw, xdone, in_xact, wt_done;

  phy_scan_eval u_eval (
    .ctrl_i(ctrl_q), .adv_i(adv_q), .pref_i(pref_adv_i), .stored_i(stored_adv),
    .autoneg_i(autoneg_i), .fdx_i(fdx_i), .spd100_i(spd100_i),
    .to_adv_o(ev_adv), .new_ctrl_o(ev_ctrl), .switch_o(ev_sw)
  );

  phy_scan_table #(.MAX_PHY(MAX_PHY)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state == S_IDLE && start_i),
    .we_i(state == S_DECIDE),
    .slot_i(cnt[SW-1:0]),
    .addr_i(idx[4:0]), .adv_i(ev_adv),
    .list_o(phy_list_o), .adv_o(stored_adv)
  );

  phy_scan_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(state == S_WCTL1 && xdone),
    .done_o(wt_done)
  );

  function automatic scan_state_e ctl_route(logic [DW-1:0] nv, logic [DW-1:0] ov, logic s);
    if (nv == ov) return S_NEXT;
    return s ? S_WCTL1 : S_WCTL2;
  endfunction

  always_comb begin
    in_xact = 1'b1;
    mdio_wr_o = 1'b0;
    mdio_reg_o = REG_STAT;
    case (state)
      S_STAT, S_STAT2: mdio_reg_o = REG_STAT;
      S_CTRL:          mdio_reg_o = REG_CTRL;
      S_ADV:           mdio_reg_o = REG_ADV;
      S_WADV:          begin mdio_reg_o = REG_ADV;  mdio_wr_o = 1'b1; end
      S_WCTL1, S_WCTL2: begin mdio_reg_o = REG_CTRL; mdio_wr_o = 1'b1; end
      default:         in_xact = 1'b0;
    endcase
  end

  assign mdio_req_o   = in_xact && !pend;
  assign mdio_phy_o   = idx[4:0];
  assign mdio_wdata_o = (state == S_WADV) ? to_adv_q : new_ctrl_q;
  assign xdone        = pend && mdio_done_i;
  assign scan_done_o  = (state == S_DONE);
  assign found_cnt_o  = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= S_IDLE;
      idx        <= '0;
      cnt        <= '0;
      pend       <= 1'b0;
      ctrl_q     <= '0;
      adv_q      <= '0;
      to_adv_q   <= '0;
      new_ctrl_q <= '0;
      sw_q       <= 1'b0;
    end else begin
      if (mdio_req_o) pend <= 1'b1;
      if (xdone)      pend <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          idx   <= 6'd1;
          cnt   <= '0;
          state <= S_STAT;
        end
        S_STAT: if (xdone) state <= phy_present(mdio_rdata_i) ? S_CTRL : S_NEXT;
        S_CTRL: if (xdone) begin
          ctrl_q <= mdio_rdata_i;
          state  <= S_ADV;
        end
        S_ADV: if (xdone) begin
          adv_q <= mdio_rdata_i;
          state <= ((mdio_rdata_i & ADV_ABIL) == '0) ? S_STAT2 : S_DECIDE;
        end
        S_STAT2: if (xdone) begin
          adv_q <= adv_from_status(mdio_rdata_i);
          state <= S_DECIDE;
        end
        S_DECIDE: begin
          to_adv_q   <= ev_adv;
          new_ctrl_q <= ev_ctrl;
          sw_q       <= ev_sw;
          cnt        <= cnt + 1'b1;
          state      <= (ev_adv != adv_q) ? S_WADV : ctl_route(ev_ctrl, ctrl_q, ev_sw);
        end
        S_WADV:  if (xdone) state <= ctl_route(new_ctrl_q, ctrl_q, sw_q);
        S_WCTL1: if (xdone) state <= S_WAIT;
        S_WAIT:  if (wt_done) state <= S_WCTL2;
        S_WCTL2: if (xdone) state <= S_NEXT;
        S_NEXT: begin
          if (idx == 6'd32 || cnt == CW'(MAX_PHY)) state <= S_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_STAT;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_scan_chk.sv
`timescale 1ns/1ps
module phy_scan_chk #(
  parameter  int MAX_PHY  = 4,
  parameter  int WAIT_CYC = 2000,
  localparam int CW = $clog2(MAX_PHY + 1),
  localparam int GW = $clog2(WAIT_CYC + 2) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mdio_req_o,
  input logic          mdio_wr_o,
  input logic [4:0]    mdio_phy_o,
  input logic [4:0]    mdio_reg_o,
  input logic [15:0]   mdio_wdata_o,
  input logic          mdio_done_i,
  input logic          scan_done_o,
  input logic [CW-1:0] found_cnt_o
);
  logic          outst;
  logic          last_ctl;
  logic [4:0]    last_phy;
  logic [GW-1:0] gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      outst    <= 1'b0;
      last_ctl <= 1'b0;
      last_phy <= '0;
      gap      <= '0;
    end else begin
      if (mdio_req_o)       outst <= 1'b1;
      else if (mdio_done_i) outst <= 1'b0;
      if (mdio_req_o) begin
        last_ctl <= mdio_wr_o && (mdio_reg_o == 5'd0);
        last_phy <= mdio_phy_o;
        gap      <= '0;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R9
  single_txn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |-> !outst);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_cnt_o <= CW'(MAX_PHY));
  // R7
  ctl_scrub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && mdio_wr_o && mdio_reg_o == 5'd0) |-> ((mdio_wdata_o & 16'hCC80) == 16'h0));
  // R5
  wr_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && mdio_wr_o) |-> (mdio_reg_o == 5'd0 || mdio_reg_o == 5'd4));
  // R8
  dbl_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_req_o && mdio_wr_o && mdio_reg_o == 5'd0 && last_ctl && mdio_phy_o == last_phy)
      |-> (gap >= GW'(WAIT_CYC)));
endmodule

bind phy_scan_seq phy_scan_chk #(.MAX_PHY(MAX_PHY), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mdio_req_o(mdio_req_o), .mdio_wr_o(mdio_wr_o),
  .mdio_phy_o(mdio_phy_o), .mdio_reg_o(mdio_reg_o), .mdio_wdata_o(mdio_wdata_o),
  .mdio_done_i(mdio_done_i), .scan_done_o(scan_done_o), .found_cnt_o(found_cnt_o)
);

// File: tb/phy_scan_seq_bench.sv
`timescale 1ns/1ps
module phy_scan_seq_bench;
  localparam int MAXP = 4;
  localparam int WAITC = 25;
  localparam int LAT = 3;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, start_i, autoneg_i, fdx_i, spd100_i;
  logic [15:0] pref_adv_i;
  logic mdio_req_o, mdio_wr_o, mdio_done_i;
  logic [4:0] mdio_phy_o, mdio_reg_o;
  logic [15:0] mdio_wdata_o, mdio_rdata_i;
  logic scan_done_o;
  logic [CW-1:0] found_cnt_o;
  logic [MAXP*5-1:0] phy_list_o;

  phy_scan_seq #(.MAX_PHY(MAXP), .WAIT_CYC(WAITC)) u_phy_scan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .autoneg_i(autoneg_i),
    .fdx_i(fdx_i), .spd100_i(spd100_i), .pref_adv_i(pref_adv_i),
    .mdio_req_o(mdio_req_o), .mdio_wr_o(mdio_wr_o), .mdio_phy_o(mdio_phy_o),
    .mdio_reg_o(mdio_reg_o), .mdio_wdata_o(mdio_wdata_o), .mdio_done_i(mdio_done_i),
    .mdio_rdata_i(mdio_rdata_i), .scan_done_o(scan_done_o), .found_cnt_o(found_cnt_o),
    .phy_list_o(phy_list_o)
  );

  logic [15:0] r_ctl [32];
  logic [15:0] r_st  [32];
  logic [15:0] r_adv [32];
  logic [15:0] m_slot [MAXP];

  int n_chk = 0, n_fail = 0;
  longint cyc = 0;
  int log_n, rd_n, done_n, last_rd;
  logic [4:0]  log_phy [64];
  logic [4:0]  log_reg [64];
  logic [15:0] log_dat [64];
  longint      log_cyc [64];
  int e_n, e_rd, e_cnt, e_last;
  logic [4:0]  e_phy [64];
  logic [4:0]  e_reg [64];
  logic [15:0] e_dat [64];
  logic [4:0]  e_list [MAXP];
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (scan_done_o) done_n++;
  end

  // MDIO master model
  initial begin
    mdio_done_i = 1'b0;
    mdio_rdata_i = '0;
    forever begin
      @(negedge clk);
      mdio_done_i = 1'b0;
      if (mdio_req_o) begin
        automatic logic w = mdio_wr_o;
        automatic logic [4:0] p = mdio_phy_o;
        automatic logic [4:0] r = mdio_reg_o;
        automatic logic [15:0] d = mdio_wdata_o;
        automatic longint c = cyc;
        repeat (LAT) @(negedge clk);
        if (w) begin
          if (log_n < 64) begin
            log_phy[log_n] = p; log_reg[log_n] = r; log_dat[log_n] = d; log_cyc[log_n] = c;
          end
          log_n++;
          if (r == 5'd0) r_ctl[p] = d;
          if (r == 5'd4) r_adv[p] = d;
          mdio_rdata_i = '0;
        end else begin
          rd_n++;
          if (r == 5'd1) last_rd = p;
          mdio_rdata_i = (r == 5'd0) ? r_ctl[p] : (r == 5'd1) ? r_st[p] : (r == 5'd4) ? r_adv[p] : 16'hFFFF;
        end
        mdio_done_i = 1'b1;
      end
    end
  end

  task automatic push_exp(logic [4:0] p, logic [4:0] r, logic [15:0] d);
    if (e_n < 64) begin e_phy[e_n] = p; e_reg[e_n] = r; e_dat[e_n] = d; end
    e_n++;
  endtask

  task automatic model_scan(bit an, bit fd, bit sp, logic [15:0] pref);
    logic [15:0] s, c, v, to, nc;
    bit sw;
    e_n = 0; e_rd = 0; e_cnt = 0; e_last = -1;
    for (int i = 1; i <= 32 && e_cnt < MAXP; i++) begin
      automatic int a = i % 32;
      s = r_st[a];
      e_rd++;
      e_last = a;
      if (!(((s & 16'h8301) == 16'h8001) || (!s[15] && (s & 16'h7800) != 0))) continue;
      c = r_ctl[a];
      v = r_adv[a];
      e_rd += 2;
      if ((v & 16'h01E0) == 0) begin
        e_rd++;
        v = ((s >> 6) & 16'h03E0) | 16'h0001;
      end
      if (pref != 0) m_slot[e_cnt] = pref;
      else if (m_slot[e_cnt] == 0) m_slot[e_cnt] = v;
      to = m_slot[e_cnt];
      e_list[e_cnt] = a[4:0];
      if (to != v) push_exp(a[4:0], 5'd4, to);
      if (an) begin
        nc = c | 16'h1000;
        sw = (nc != c);
        if (sw) nc = nc | 16'h0200;
      end else begin
        nc = c & ~16'h1000;
        sw = (nc != c);
      end
      nc = nc & ~16'hED80;
      if (fd) nc = nc | 16'h0100;
      if (sp) nc = nc | 16'h2000;
      if (nc != c) begin
        if (sw) push_exp(a[4:0], 5'd0, nc);
        push_exp(a[4:0], 5'd0, nc);
      end
      e_cnt++;
    end
  endtask

  task automatic fill_absent();
    for (int a = 0; a < 32; a++) begin
      r_st[a] = 16'hFFFF; r_ctl[a] = 16'h0000; r_adv[a] = 16'h0000;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int k = 0; k < MAXP; k++) m_slot[k] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_scan(bit an, bit fd, bit sp, logic [15:0] pref, bit poke);
    int t;
    autoneg_i = an; fdx_i = fd; spd100_i = sp; pref_adv_i = pref;
    model_scan(an, fd, sp, pref);
    log_n = 0; rd_n = 0; done_n = 0; last_rd = -1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    t = 0;
    while (!scan_done_o && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(t < 20000, "R9", "scan timeout", t, 0);
    repeat (4) @(negedge clk);
    check(done_n == 1, "R9", "done pulses", done_n, 1);
    check(found_cnt_o == CW'(e_cnt), "R3", "found count", found_cnt_o, e_cnt);
    for (int k = 0; k < e_cnt; k++)
      check(phy_list_o[k*5 +: 5] == e_list[k], "R1", "list entry", phy_list_o[k*5 +: 5], e_list[k]);
    check(rd_n == e_rd, "R2 R4", "read count", rd_n, e_rd);
    check(last_rd == e_last, "R1 R2", "last probed address", last_rd, e_last);
    check(log_n == e_n, "R8", "write count", log_n, e_n);
    for (int k = 0; k < e_n && k < log_n && k < 64; k++) begin
      if (e_reg[k] == 5'd4)
        check(log_reg[k] == 5'd4 && log_phy[k] == e_phy[k] && log_dat[k] == e_dat[k],
              "R5", "adv write", {log_phy[k], log_reg[k], log_dat[k]}, {e_phy[k], e_reg[k], e_dat[k]});
      else
        check(log_reg[k] == 5'd0 && log_phy[k] == e_phy[k] && log_dat[k] == e_dat[k],
              "R6 R7", "ctrl write", {log_phy[k], log_reg[k], log_dat[k]}, {e_phy[k], e_reg[k], e_dat[k]});
      if (k > 0 && e_reg[k] == 5'd0 && e_reg[k-1] == 5'd0 && e_phy[k] == e_phy[k-1])
        check(log_cyc[k] - log_cyc[k-1] >= WAITC, "R8", "double write gap",
              log_cyc[k] - log_cyc[k-1], WAITC);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; autoneg_i = 1'b0; fdx_i = 1'b0; spd100_i = 1'b0;
    pref_adv_i = '0;
    for (int k = 0; k < MAXP; k++) m_slot[k] = '0;
    fill_absent();
    repeat (4) @(negedge clk);
    // R10 reset state
    check(mdio_req_o == 1'b0, "R10", "req in reset", mdio_req_o, 0);
    check(scan_done_o == 1'b0, "R10", "done in reset", scan_done_o, 0);
    check(found_cnt_o == '0, "R10", "count in reset", found_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(mdio_req_o == 1'b0, "R10", "idle without start", mdio_req_o, 0);

    // empty bus
    fill_absent();
    run_scan(1, 0, 0, 16'h0, 0);

    // only addresses 31 and 0: address 0 comes last (R1)
    fill_absent();
    r_st[31] = 16'h7809; r_ctl[31] = 16'h3100; r_adv[31] = 16'h01E1;
    r_st[0]  = 16'h8001; r_ctl[0]  = 16'h0000; r_adv[0]  = 16'h0000;
    run_scan(1, 1, 1, 16'h0, 0);

    // full bus: table fills early (R2); stray start ignored (R9)
    for (int a = 0; a < 32; a++) begin
      r_st[a] = 16'h786D; r_ctl[a] = 16'(a * 16'h0911); r_adv[a] = (a % 2) ? 16'h0000 : 16'h0061;
    end
    run_scan(0, 0, 1, 16'h0, 1);

    // status pattern sweep (R3 R4 R5 R6 R7 R8)
    for (int p = 0; p < 256; p++) begin
      automatic logic [7:0] b = p[7:0];
      automatic int a = (p * 7) % 32;
      if (p % 16 == 1) do_reset();
      fill_absent();
      r_st[a]  = {b[7], b[6], b[5], b[4], b[3], 1'b0, b[2], b[1], 7'b0, b[0]};
      r_ctl[a] = 16'(p * 16'h0123) ^ 16'h1200;
      r_adv[a] = b[4] ? (16'(p << 5) & 16'h01E0) : 16'h0000;
      r_st[(a + 5) % 32]  = 16'h7809;
      r_ctl[(a + 5) % 32] = 16'(p * 16'h0311);
      r_adv[(a + 5) % 32] = 16'h0000;
      run_scan(b[0], b[1], b[2], (p % 5 == 0) ? 16'h05E1 : ((p % 7 == 0) ? 16'h0061 : 16'h0), 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule